// File: doc/BRIEF.md
# Second-Operand Shifter Unit

This unit builds the second operand of a 32-bit data-processing instruction. It needs no clock. It reads the low twelve bits of the instruction word, the value already read from the shifted source register, and the value of a second register that can give the shift count. It returns the finished 32-bit operand and the carry that a flag-setting instruction would record.

A select input picks the form of the operand. In the constant form, an 8-bit constant is widened with zeros and rotated right by an even count. In the register form, the register value is shifted or rotated. The count comes either from a 5-bit field in the instruction or from the low byte of the second register. Register reads, the arithmetic unit, flag storage and condition checking sit in the neighbouring blocks.

The operand and the carry depend only on the present inputs. They settle within the same cycle in which the inputs are applied.

Top module: `opnd_shifter`

## Requirements
- R1: With `imm_sel`=1, `operand` is `op_field[7:0]` widened with zeros to 32 bits and rotated right by twice the unsigned value of `op_field[11:8]`, so the count is even and lies between 0 and 30.
- R2: With `imm_sel`=1, `carry_out` is `carry_in` when `op_field[11:8]` is zero. Otherwise it is bit 31 of `operand`.
- R3: With `imm_sel`=0, `op_field[6:5]` selects the shift kind: 00 is logical left, 01 is logical right, 10 is arithmetic right (the sign bit fills vacated positions) and 11 is rotate right. When `op_field[4]`=0, the count is the unsigned value of `op_field[11:7]`, applied to `rm_val`.
- R4: With `imm_sel`=0 and `op_field[4]`=1, the count is `rs_val[7:0]` taken as unsigned. Neither `rs_val[31:8]` nor `op_field[7]` has any effect on `operand` or `carry_out`. `op_field[3:0]` never affects the outputs.
- R5: With `imm_sel`=0 and a count of zero from either source, `operand` equals `rm_val` and `carry_out` equals `carry_in`, whatever the shift kind. An all-zero `op_field` therefore passes `rm_val` through unchanged.
- R6: For a register-form count n from 1 to 31, `carry_out` is the last bit moved out. For logical left this is `rm_val[32-n]`. For logical right and arithmetic right it is `rm_val[n-1]`. For rotate right it uses the same rule, with n taken modulo 32.
- R7: For logical left and logical right, a count of exactly 32 gives `operand`=0, and `carry_out` is `rm_val[0]` for left or `rm_val[31]` for right. A count above 32 gives `operand`=0 and `carry_out`=0.
- R8: For arithmetic right, a count of 32 or more gives an `operand` made of 32 copies of `rm_val[31]`, and `carry_out` equals `rm_val[31]`.
- R9: For rotate right, the count is used modulo 32. When a nonzero count is a multiple of 32, `operand` equals `rm_val` and `carry_out` equals `rm_val[31]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| imm_sel | input | 1 | 1 selects the rotated-constant form, 0 the shifted-register form |
| op_field | input | 12 | Low twelve bits of the instruction word |
| rm_val | input | 32 | Value of the register to be shifted |
| rs_val | input | 32 | Value of the register that can supply the shift count |
| carry_in | input | 1 | Present carry flag, returned when nothing is shifted |
| operand | output | 32 | Finished second operand |
| carry_out | output | 1 | Carry produced by the shifter |

## Verification
The unit holds no state. The internal values that can go wrong are the decoded shift request (its kind, its count and the value to be shifted) and the range flags taken from the count. A wrong request shows at `operand` and `carry_out` in the same cycle as the inputs that caused it. A mis-decoded kind or count source changes the operand bits. A wrong range flag shows only at the edges: counts of 0, 32, 33 and higher, and rotations by multiples of 32. For that reason the directed cases concentrate on those counts, on both count sources, and on inputs whose sign bit and carry-in are set.

// File: rtl/opnd_shift_pkg.sv
package opnd_shift_pkg;

    localparam int XLEN    = 32;
    localparam int AMT_W   = 8;
    localparam int FIELD_W = 12;
    localparam int SH_W    = $clog2(XLEN);
    localparam int IMM_W   = 8;
    localparam int ROT_W   = 4;
    localparam int CAMT_W  = 5;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        shift_kind_e        kind;
        logic [AMT_W-1:0]   amount;
        logic [XLEN-1:0]    value;
    } shift_req_t;

    typedef struct packed {
        logic [XLEN-1:0]    value;
        logic               carry;
    } shift_res_t;

    function automatic logic [AMT_W-1:0] even_rotation(input logic [ROT_W-1:0] field);
        return AMT_W'({field, 1'b0});
    endfunction

endpackage

// File: rtl/opnd_field_decode.sv
module opnd_field_decode
    import opnd_shift_pkg::*;
(
    input  logic               imm_sel,
    input  logic [FIELD_W-1:0] op_field,
    input  logic [XLEN-1:0]    rm_val,
    input  logic [AMT_W-1:0]   rs_low,
    output shift_req_t         req
);

    localparam int ROT_LO  = IMM_W;
    localparam int KIND_LO = 5;
    localparam int SRC_BIT = 4;
    localparam int CAMT_LO = 7;

    logic unused_field_bits;
    assign unused_field_bits = ^op_field[3:0];

    always_comb begin
        if (imm_sel) begin
            req.kind   = SH_ROR;
            req.amount = even_rotation(op_field[ROT_LO +: ROT_W]);
            req.value  = XLEN'(op_field[IMM_W-1:0]);
        end else begin
            req.kind   = shift_kind_e'(op_field[KIND_LO +: 2]);
            req.amount = op_field[SRC_BIT] ? rs_low
                                           : AMT_W'(op_field[CAMT_LO +: CAMT_W]);
            req.value  = rm_val;
        end
    end

endmodule

// File: rtl/opnd_barrel_core.sv
module opnd_barrel_core
    import opnd_shift_pkg::*;
(
    input  shift_req_t req,
    input  logic       carry_in,
    output shift_res_t res
);

    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(XLEN);

    logic [SH_W-1:0] lo;
    logic [SH_W-1:0] lo_m1;
    logic [SH_W:0]   inv;
    logic            zero_amt;
    logic            in_range;
    logic            at_full;
    logic            msb;

    assign lo       = req.amount[SH_W-1:0];
    assign lo_m1    = lo - SH_W'(1);
    assign inv      = (SH_W+1)'(XLEN) - {1'b0, lo};
    assign zero_amt = (req.amount == '0);
    assign in_range = (req.amount < FULL_AMT);
    assign at_full  = (req.amount == FULL_AMT);
    assign msb      = req.value[XLEN-1];

    always_comb begin
        res.value = req.value;
        res.carry = carry_in;
        if (!zero_amt) begin
            unique case (req.kind)
                SH_LSL: begin
                    if (in_range) begin
                        res.value = req.value << lo;
                        res.carry = req.value[inv[SH_W-1:0]];
                    end else if (at_full) begin
                        res.value = '0;
                        res.carry = req.value[0];
                    end else begin
                        res.value = '0;
                        res.carry = 1'b0;
                    end
                end
                SH_LSR: begin
                    if (in_range) begin
                        res.value = req.value >> lo;
                        res.carry = req.value[lo_m1];
                    end else if (at_full) begin
                        res.value = '0;
                        res.carry = msb;
                    end else begin
                        res.value = '0;
                        res.carry = 1'b0;
                    end
                end
                SH_ASR: begin
                    if (in_range) begin
                        res.value = $unsigned($signed(req.value) >>> lo);
                        res.carry = req.value[lo_m1];
                    end else begin
                        res.value = {XLEN{msb}};
                        res.carry = msb;
                    end
                end
                SH_ROR: begin
                    if (lo == '0) begin
                        res.value = req.value;
                        res.carry = msb;
                    end else begin
                        res.value = (req.value >> lo) | (req.value << inv);
                        res.carry = req.value[lo_m1];
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
    import opnd_shift_pkg::*;
(
    input  logic               imm_sel,
    input  logic [FIELD_W-1:0] op_field,
    input  logic [XLEN-1:0]    rm_val,
    input  logic [XLEN-1:0]    rs_val,
    input  logic               carry_in,
    output logic [XLEN-1:0]    operand,
    output logic               carry_out
);

    shift_req_t req;
    shift_res_t res;

    logic unused_rs_high;
    assign unused_rs_high = ^rs_val[XLEN-1:AMT_W];

    opnd_field_decode u_decode (
        .imm_sel  (imm_sel),
        .op_field (op_field),
        .rm_val   (rm_val),
        .rs_low   (rs_val[AMT_W-1:0]),
        .req      (req)
    );

    opnd_barrel_core u_core (
        .req      (req),
        .carry_in (carry_in),
        .res      (res)
    );

    assign operand   = res.value;
    assign carry_out = res.carry;

endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk (
    input logic        imm_sel,
    input logic [11:0] op_field,
    input logic [31:0] rm_val,
    input logic [31:0] rs_val,
    input logic        carry_in,
    input logic [31:0] operand,
    input logic        carry_out
);

    logic       known;
    logic [1:0] kind;
    logic       reg_src;
    logic [7:0] rs_low;
    logic       unused_chk;

    assign known      = !$isunknown({imm_sel, op_field, rm_val, rs_val, carry_in});
    assign kind       = op_field[6:5];
    assign reg_src    = op_field[4];
    assign rs_low     = rs_val[7:0];
    assign unused_chk = ^{op_field[3:0], rs_val[31:8]};

    always_comb begin
        if (known) begin
            if (imm_sel) begin
                assert_imm_ones_R1: assert ($countones(operand) == $countones(op_field[7:0]));
                if (op_field[11:8] != 4'd0) begin
                    assert_imm_carry_R2: assert (carry_out == operand[31]);
                end else begin
                    assert_imm_norot_R2: assert (carry_out == carry_in && operand == {24'd0, op_field[7:0]});
                end
            end else begin
                if (!reg_src && op_field[11:7] == 5'd0) begin
                    assert_const_zero_R5: assert (operand == rm_val && carry_out == carry_in);
                end
                if (reg_src && rs_low == 8'd0) begin
                    assert_reg_zero_R5: assert (operand == rm_val && carry_out == carry_in);
                end
                if (!reg_src && kind == 2'b01 && op_field[11:7] != 5'd0) begin
                    assert_lsr_top_R3: assert (operand[31] == 1'b0);
                end
                if (reg_src && rs_low > 8'd32 && !kind[1]) begin
                    assert_wide_logic_R7: assert (operand == 32'd0 && carry_out == 1'b0);
                end
                if (reg_src && rs_low >= 8'd32 && kind == 2'b10) begin
                    assert_asr_fill_R8: assert (operand == {32{rm_val[31]}} && carry_out == rm_val[31]);
                end
                if (kind == 2'b11) begin
                    assert_ror_ones_R9: assert ($countones(operand) == $countones(rm_val));
                end
            end
        end
    end

endmodule

bind opnd_shifter opnd_shifter_chk u_chk (
    .imm_sel   (imm_sel),
    .op_field  (op_field),
    .rm_val    (rm_val),
    .rs_val    (rs_val),
    .carry_in  (carry_in),
    .operand   (operand),
    .carry_out (carry_out)
);

// File: tb/opnd_shifter_bench.sv
module opnd_shifter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        imm_sel = 1'b0;
    logic [11:0] op_field = '0;
    logic [31:0] rm_val = '0;
    logic [31:0] rs_val = '0;
    logic        carry_in = 1'b0;
    logic [31:0] operand;
    logic        carry_out;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opnd_shifter u_opnd_shifter (
        .imm_sel   (imm_sel),
        .op_field  (op_field),
        .rm_val    (rm_val),
        .rs_val    (rs_val),
        .carry_in  (carry_in),
        .operand   (operand),
        .carry_out (carry_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<%0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Step-by-step model written from the requirements: one position per step.
    function automatic logic [32:0] expect_of(input logic im, input logic [11:0] op,
                                              input logic [31:0] rm, input logic [31:0] rs,
                                              input logic ci);
        logic [31:0] v;
        logic        c;
        int          n;
        c = ci;
        if (im) begin
            v = {24'd0, op[7:0]};
            n = 2 * int'(op[11:8]);
            for (int i = 0; i < n; i++) begin
                c = v[0];
                v = {v[0], v[31:1]};
            end
        end else begin
            v = rm;
            n = op[4] ? int'(rs[7:0]) : int'(op[11:7]);
            case (op[6:5])
                2'b00: for (int i = 0; i < n; i++) begin c = v[31]; v = {v[30:0], 1'b0}; end
                2'b01: for (int i = 0; i < n; i++) begin c = v[0]; v = {1'b0, v[31:1]}; end
                2'b10: for (int i = 0; i < n; i++) begin c = v[0]; v = {v[31], v[31:1]}; end
                default: begin
                    if (n != 0 && (n % 32) == 0) c = v[31];
                    for (int i = 0; i < (n % 32); i++) begin c = v[0]; v = {v[0], v[31:1]}; end
                end
            endcase
        end
        return {c, v};
    endfunction

    function automatic logic [11:0] f_const(input logic [1:0] kind, input logic [4:0] amt);
        return {amt, kind, 1'b0, 4'd3};
    endfunction

    function automatic logic [11:0] f_reg(input logic [1:0] kind, input logic b7);
        return {4'd5, b7, kind, 1'b1, 4'd3};
    endfunction

    task automatic apply_check(input string tag, input logic im, input logic [11:0] op,
                               input logic [31:0] rm, input logic [31:0] rs, input logic ci);
        logic [32:0] exp;
        @(posedge clk);
        imm_sel  = im;
        op_field = op;
        rm_val   = rm;
        rs_val   = rs;
        carry_in = ci;
        @(negedge clk);
        exp = expect_of(im, op, rm, rs, ci);
        n_tests = n_tests + 1;
        if (operand !== exp[31:0] || carry_out !== exp[32]) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: op=%h rm=%h rs=%h cin=%b actual=%h/%b expected=%h/%b",
                     tag, op, rm, rs, ci, operand, carry_out, exp[31:0], exp[32]);
        end
    endtask

    task automatic test_idle_R5;
        apply_check("R5 all-zero inputs", 1'b0, 12'd0, 32'd0, 32'd0, 1'b0);
        apply_check("R5 zero fields pass rm", 1'b0, 12'd0, 32'hDEADBEEF, 32'd0, 1'b1);
        for (int k = 0; k < 4; k++) begin
            apply_check("R5 const count 0", 1'b0, f_const(2'(k), 5'd0), 32'h8000_0001, 32'd0, 1'b1);
            apply_check("R5 reg count 0", 1'b0, f_reg(2'(k), 1'b0), 32'hC000_0003, 32'hFFFF_FF00, 1'b1);
        end
    endtask

    task automatic test_immediate_R1_R2;
        for (int r = 0; r < 16; r++) begin
            apply_check("R1 R2 rotated const 0x0A", 1'b1, {4'(r), 8'h0A}, 32'hFFFF_FFFF, 32'd7, r[0]);
            apply_check("R1 R2 rotated const 0x81", 1'b1, {4'(r), 8'h81}, 32'd0, 32'd0, 1'b1);
        end
        apply_check("R2 rot 0 keeps cin", 1'b1, 12'h0FF, 32'd0, 32'd0, 1'b1);
    endtask

    task automatic test_const_R3_R6;
        logic [4:0]  amts [4] = '{5'd1, 5'd3, 5'd16, 5'd31};
        logic [31:0] pats [3] = '{32'h8000_0001, 32'h4A01_82F3, 32'hF0F0_0F0F};
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 4; a++)
                for (int p = 0; p < 3; p++)
                    apply_check("R3 R6 constant count", 1'b0, f_const(2'(k), amts[a]), pats[p], 32'hFFFF_FFFF, p[0]);
    endtask

    task automatic test_reg_source_R4;
        for (int k = 0; k < 4; k++) begin
            apply_check("R4 rs count 4", 1'b0, f_reg(2'(k), 1'b0), 32'h9234_5678, 32'h0000_0004, 1'b0);
            apply_check("R4 rs upper ignored", 1'b0, f_reg(2'(k), 1'b0), 32'h9234_5678, 32'hABCD_EF04, 1'b0);
            apply_check("R4 bit7 ignored", 1'b0, f_reg(2'(k), 1'b1), 32'h9234_5678, 32'h0000_0004, 1'b0);
            apply_check("R4 rs count 17", 1'b0, f_reg(2'(k), 1'b0), 32'h1357_9BDF, 32'h7700_0011, 1'b1);
        end
        apply_check("R4 rm index ignored", 1'b0, {5'd7, 2'b01, 1'b0, 4'hF}, 32'hFFFF_0000, 32'd0, 1'b0);
    endtask

    task automatic test_logic_edges_R7;
        logic [7:0] cnt [4] = '{8'd31, 8'd32, 8'd33, 8'd200};
        for (int k = 0; k < 2; k++)
            for (int c = 0; c < 4; c++) begin
                apply_check("R7 logical edge", 1'b0, f_reg(2'(k), 1'b0), 32'h8000_0001, {24'd0, cnt[c]}, 1'b1);
                apply_check("R7 logical edge alt", 1'b0, f_reg(2'(k), 1'b0), 32'h7FFF_FFFE, {24'd0, cnt[c]}, 1'b1);
            end
    endtask

    task automatic test_arith_R8;
        logic [7:0] cnt [4] = '{8'd31, 8'd32, 8'd100, 8'd255};
        for (int c = 0; c < 4; c++) begin
            apply_check("R8 asr negative", 1'b0, f_reg(2'b10, 1'b0), 32'h8000_1234, {24'd0, cnt[c]}, 1'b0);
            apply_check("R8 asr positive", 1'b0, f_reg(2'b10, 1'b0), 32'h7FFF_1234, {24'd0, cnt[c]}, 1'b1);
        end
    endtask

    task automatic test_rotate_R9;
        logic [7:0] cnt [5] = '{8'd32, 8'd64, 8'd37, 8'd255, 8'd96};
        for (int c = 0; c < 5; c++) begin
            apply_check("R9 ror modulo", 1'b0, f_reg(2'b11, 1'b0), 32'h8421_0F0E, {24'd0, cnt[c]}, 1'b0);
            apply_check("R9 ror modulo alt", 1'b0, f_reg(2'b11, 1'b0), 32'h0421_0F01, {24'd0, cnt[c]}, 1'b1);
        end
    endtask

    initial begin
        test_idle_R5();
        test_immediate_R1_R2();
        test_const_R3_R6();
        test_reg_source_R4();
        test_logic_edges_R7();
        test_arith_R8();
        test_rotate_R9();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule